// File: doc/BRIEF.md
# Virtual-8086 Interrupt Entry Frame Sequencer

This block carries out the stack work for an interrupt taken while the processor runs in virtual-8086 mode and is served by a privilege-0 handler. When a request arrives, the block first checks whether the event may enter ring 0 at all. If it may not, the block reports a general-protection fault with a zero error code. It then makes no memory write and leaves its register outputs unchanged.

When the event is allowed, the block first switches to the ring-0 stack taken from the task state. It then writes nine 32-bit words through a ready/valid write port:
- the four data segment registers;
- the old stack segment and stack pointer;
- the original flags;
- the code segment and instruction pointer.

After the four data segment registers have been written, it clears them to zero. At the end it loads the handler entry point and pulses a completion flag. Segment base translation, descriptor checks and the memory itself sit outside the block.

The surrounding control logic presents every input value together with a one-cycle start strobe. It reads the updated register file from the outputs once done or fault has pulsed.

Top module: `v86_int_frame_seq`

## Requirements
- R1: A start strobe is taken only while busy_o is low. A strobe seen while busy_o is high changes neither the frame nor any register output.
- R2: IOPL is bits 13:12 of eflags_i. When IOPL is below 3, fault_gp_o pulses for one cycle in the cycle after the strobe. No memory request is made and no register output changes.
- R3: When IOPL equals 3 but gate_dpl_i is not 3, or tgt_cpl_i is not 0, the block behaves exactly as in R2.
- R4: In the cycle after an accepted strobe, ss_o and esp_o show ss0_i and esp0_i. In the same cycle, eflags_o shows eflags_i with bit 17 (VM) and bit 8 (TF) cleared. Bit 9 (IF) is cleared only when gate_int_i is 1.
- R5: Every write request uses address esp_o minus 4. Each write accepted with mem_rdy_i high lowers esp_o by 4. While mem_rdy_i is low, the request, address and data hold steady.
- R6: The nine write words come in this order: GS, FS, DS, ES, old SS, old ESP, the unmodified old flags, CS, EIP. Each 16-bit value is zero-extended in the upper half.
- R7: Once the ES write is accepted, gs_o, fs_o, ds_o and es_o read zero.
- R8: After the ninth write is accepted, cs_o and eip_o hold hsel_i and hoff_i as they were at the strobe, and esp_o equals esp0_i minus 36. In that same next cycle done_o is high for exactly one cycle.
- R9: After reset, every register output reads zero, and busy_o, mem_req_o, done_o and fault_gp_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| gate_int_i | input | 1 | 1 = interrupt gate (clears IF), 0 = trap gate |
| gate_dpl_i | input | 2 | Privilege level of the gate |
| tgt_cpl_i | input | 2 | Privilege level of the handler code segment |
| gs_i | input | 16 | Current GS |
| fs_i | input | 16 | Current FS |
| ds_i | input | 16 | Current DS |
| es_i | input | 16 | Current ES |
| ss_i | input | 16 | Current SS |
| esp_i | input | 32 | Current stack pointer |
| eflags_i | input | 32 | Current flags |
| cs_i | input | 16 | Current CS |
| eip_i | input | 32 | Current instruction pointer |
| ss0_i | input | 16 | Ring-0 stack segment from task state |
| esp0_i | input | 32 | Ring-0 stack pointer from task state |
| hsel_i | input | 16 | Handler code selector from gate |
| hoff_i | input | 32 | Handler offset from gate |
| busy_o | output | 1 | Sequence in progress |
| mem_req_o | output | 1 | Write request valid |
| mem_addr_o | output | 32 | Write address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdy_i | input | 1 | Write accepted |
| gs_o | output | 16 | GS register |
| fs_o | output | 16 | FS register |
| ds_o | output | 16 | DS register |
| es_o | output | 16 | ES register |
| ss_o | output | 16 | SS register |
| esp_o | output | 32 | Stack pointer register |
| eflags_o | output | 32 | Flags register |
| cs_o | output | 16 | CS register |
| eip_o | output | 32 | Instruction pointer register |
| done_o | output | 1 | One-cycle completion pulse |
| fault_gp_o | output | 1 | One-cycle GP(0) pulse |

## Verification
Interrupt-gate and trap-gate entries are run with flags that have VM, TF and IF all set. This shows whether IF is cleared only for the gate kind that should clear it, while the pushed copy keeps all three bits. Some frames are written with the memory always ready and others against an irregular ready pattern. Together these separate correct stack-pointer stepping and request holding from word-order mistakes. Rejections with IOPL 0 and 2, with a gate DPL of 2 and with a target CPL of 1 each test one term of the permission rule on its own. A second strobe given in the middle of a frame with different segment values shows whether the block ignores requests while busy.

// File: rtl/v86_seq_pkg.sv
package v86_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_DONE, ST_FAULT} seq_state_e;
  localparam int FL_TF      = 8;
  localparam int FL_IF      = 9;
  localparam int FL_IOPL_LO = 12;
  localparam int FL_VM      = 17;
  localparam int SEG_WORDS   = 4;   // GS, FS, DS, ES
  localparam int FRAME_WORDS = 9;
endpackage

// File: rtl/v86_gate_check.sv
module v86_gate_check (
  input  logic [1:0] iopl_i,
  input  logic [1:0] gate_dpl_i,
  input  logic [1:0] tgt_cpl_i,
  output logic       gp_o
);
  // Entry from v86 needs IOPL 3, a DPL-3 gate and a ring-0 target.
  assign gp_o = (iopl_i != 2'd3) || (gate_dpl_i != 2'd3) || (tgt_cpl_i != 2'd0);
endmodule

// File: rtl/v86_frame_sel.sv
module v86_frame_sel
  import v86_seq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SEG_W  = 16,
  localparam int IDX_W = $clog2(FRAME_WORDS)
) (
  input  logic [SEG_W-1:0]  seg_i [SEG_WORDS],
  input  logic [SEG_W-1:0]  ss_i,
  input  logic [WORD_W-1:0] esp_i,
  input  logic [WORD_W-1:0] fl_i,
  input  logic [SEG_W-1:0]  cs_i,
  input  logic [WORD_W-1:0] eip_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int PAD_W = WORD_W - SEG_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_WORDS - 1);

  logic [WORD_W-1:0] slot [FRAME_WORDS];

  for (genvar g = 0; g < SEG_WORDS; g++) begin : g_seg
    assign slot[g] = {{PAD_W{1'b0}}, seg_i[g]};
  end
  assign slot[SEG_WORDS]     = {{PAD_W{1'b0}}, ss_i};
  assign slot[SEG_WORDS + 1] = esp_i;
  assign slot[SEG_WORDS + 2] = fl_i;
  assign slot[SEG_WORDS + 3] = {{PAD_W{1'b0}}, cs_i};
  assign slot[SEG_WORDS + 4] = eip_i;

  assign word_o = (idx_i <= LAST) ? slot[idx_i] : '0;
endmodule

// File: rtl/v86_int_frame_seq.sv
module v86_int_frame_seq
  import v86_seq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SEG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              gate_int_i,
  input  logic [1:0]        gate_dpl_i,
  input  logic [1:0]        tgt_cpl_i,
  input  logic [SEG_W-1:0]  gs_i,
  input  logic [SEG_W-1:0]  fs_i,
  input  logic [SEG_W-1:0]  ds_i,
  input  logic [SEG_W-1:0]  es_i,
  input  logic [SEG_W-1:0]  ss_i,
  input  logic [WORD_W-1:0] esp_i,
  input  logic [WORD_W-1:0] eflags_i,
  input  logic [SEG_W-1:0]  cs_i,
  input  logic [WORD_W-1:0] eip_i,
  input  logic [SEG_W-1:0]  ss0_i,
  input  logic [WORD_W-1:0] esp0_i,
  input  logic [SEG_W-1:0]  hsel_i,
  input  logic [WORD_W-1:0] hoff_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_rdy_i,
  output logic [SEG_W-1:0]  gs_o,
  output logic [SEG_W-1:0]  fs_o,
  output logic [SEG_W-1:0]  ds_o,
  output logic [SEG_W-1:0]  es_o,
  output logic [SEG_W-1:0]  ss_o,
  output logic [WORD_W-1:0] esp_o,
  output logic [WORD_W-1:0] eflags_o,
  output logic [SEG_W-1:0]  cs_o,
  output logic [WORD_W-1:0] eip_o,
  output logic              done_o,
  output logic              fault_gp_o
);
  localparam int IDX_W = $clog2(FRAME_WORDS);
  localparam logic [WORD_W-1:0] STEP_W   = WORD_W'(WORD_W / 8);
  localparam logic [IDX_W-1:0]  LAST     = IDX_W'(FRAME_WORDS - 1);
  localparam logic [IDX_W-1:0]  LAST_SEG = IDX_W'(SEG_WORDS - 1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SEG_W-1:0]  seg_q [SEG_WORDS];
  logic [SEG_W-1:0]  ss_q, cs_q, old_ss_q, hsel_q;
  logic [WORD_W-1:0] esp_q, fl_q, eip_q, old_esp_q, old_fl_q, hoff_q;
  logic [WORD_W-1:0] fl_new;
  logic              gp;

  v86_gate_check u_gate_check (
    .iopl_i     (eflags_i[FL_IOPL_LO +: 2]),
    .gate_dpl_i (gate_dpl_i),
    .tgt_cpl_i  (tgt_cpl_i),
    .gp_o       (gp)
  );

  v86_frame_sel #(.WORD_W(WORD_W), .SEG_W(SEG_W)) u_frame_sel (
    .seg_i  (seg_q),
    .ss_i   (old_ss_q),
    .esp_i  (old_esp_q),
    .fl_i   (old_fl_q),
    .cs_i   (cs_q),
    .eip_i  (eip_q),
    .idx_i  (idx_q),
    .word_o (mem_wdata_o)
  );

  always_comb begin
    fl_new        = eflags_i;
    fl_new[FL_VM] = 1'b0;
    fl_new[FL_TF] = 1'b0;
    if (gate_int_i) fl_new[FL_IF] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      for (int k = 0; k < SEG_WORDS; k++) seg_q[k] <= '0;
      ss_q      <= '0;
      cs_q      <= '0;
      old_ss_q  <= '0;
      hsel_q    <= '0;
      esp_q     <= '0;
      fl_q      <= '0;
      eip_q     <= '0;
      old_esp_q <= '0;
      old_fl_q  <= '0;
      hoff_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (gp) begin
            state_q <= ST_FAULT;
          end else begin
            state_q   <= ST_PUSH;
            idx_q     <= '0;
            seg_q[0]  <= gs_i;
            seg_q[1]  <= fs_i;
            seg_q[2]  <= ds_i;
            seg_q[3]  <= es_i;
            old_ss_q  <= ss_i;
            old_esp_q <= esp_i;
            old_fl_q  <= eflags_i;
            ss_q      <= ss0_i;     // stack switch precedes first push
            esp_q     <= esp0_i;
            fl_q      <= fl_new;
            cs_q      <= cs_i;
            eip_q     <= eip_i;
            hsel_q    <= hsel_i;
            hoff_q    <= hoff_i;
          end
        end
        ST_PUSH: if (mem_rdy_i) begin
          esp_q <= esp_q - STEP_W;
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_SEG)
            for (int k = 0; k < SEG_WORDS; k++) seg_q[k] <= '0;
          if (idx_q == LAST) begin
            state_q <= ST_DONE;
            cs_q    <= hsel_q;
            eip_q   <= hoff_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign mem_req_o  = (state_q == ST_PUSH);
  assign mem_addr_o = esp_q - STEP_W;
  assign done_o     = (state_q == ST_DONE);
  assign fault_gp_o = (state_q == ST_FAULT);
  assign gs_o       = seg_q[0];
  assign fs_o       = seg_q[1];
  assign ds_o       = seg_q[2];
  assign es_o       = seg_q[3];
  assign ss_o       = ss_q;
  assign esp_o      = esp_q;
  assign eflags_o   = fl_q;
  assign cs_o       = cs_q;
  assign eip_o      = eip_q;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !done_o);
  assert_fault_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_gp_o |-> !mem_req_o && $stable(esp_o) && $stable(eflags_o) && $stable(gs_o));
  assert_flags_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !eflags_o[FL_VM] && !eflags_o[FL_TF]);
  assert_esp_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rdy_i |=> esp_o == $past(esp_o) - STEP_W);
  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));
  assert_segs_null_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> gs_o == '0 && fs_o == '0 && ds_o == '0 && es_o == '0);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/tb_v86_int_frame_seq.sv
`timescale 1ns/1ps
module tb_v86_int_frame_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, gint = 1'b0, rdy = 1'b1;
  logic [1:0] gdpl = '0, tcpl = '0;
  logic [15:0] gs = '0, fs = '0, ds = '0, es = '0, ss = '0, cs = '0, ss0 = '0, hsel = '0;
  logic [31:0] esp = '0, fl = '0, eip = '0, esp0 = '0, hoff = '0;
  logic busy, req, done, fgp;
  logic [31:0] addr, wdata, esp_d, fl_d, eip_d;
  logic [15:0] gs_d, fs_d, ds_d, es_d, ss_d, cs_d;

  int errs = 0, checks = 0, cyc = 0;
  int stall_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  always #2 clk = ~clk;

  v86_int_frame_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .gate_int_i(gint),
    .gate_dpl_i(gdpl), .tgt_cpl_i(tcpl),
    .gs_i(gs), .fs_i(fs), .ds_i(ds), .es_i(es), .ss_i(ss), .esp_i(esp),
    .eflags_i(fl), .cs_i(cs), .eip_i(eip), .ss0_i(ss0), .esp0_i(esp0),
    .hsel_i(hsel), .hoff_i(hoff),
    .busy_o(busy), .mem_req_o(req), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdy_i(rdy),
    .gs_o(gs_d), .fs_o(fs_d), .ds_o(ds_d), .es_o(es_d), .ss_o(ss_d),
    .esp_o(esp_d), .eflags_o(fl_d), .cs_o(cs_d), .eip_o(eip_d),
    .done_o(done), .fault_gp_o(fgp)
  );

  // Behavioural reference: 0 idle, 1 writing, 2 done, 3 fault
  int m_st = 0, m_n = 0;
  logic [15:0] m_gs = '0, m_fs = '0, m_ds = '0, m_es = '0, m_ss = '0, m_cs = '0, m_hsel = '0;
  logic [31:0] m_esp = '0, m_fl = '0, m_eip = '0, m_hoff = '0;
  logic [31:0] q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0;
    end else begin
      case (m_st)
        0: if (start) begin
          if (fl[13:12] != 2'd3 || gdpl != 2'd3 || tcpl != 2'd0) m_st = 3;
          else begin
            q = {};
            q.push_back({16'h0, gs}); q.push_back({16'h0, fs});
            q.push_back({16'h0, ds}); q.push_back({16'h0, es});
            q.push_back({16'h0, ss}); q.push_back(esp); q.push_back(fl);
            q.push_back({16'h0, cs}); q.push_back(eip);
            m_gs = gs; m_fs = fs; m_ds = ds; m_es = es;
            m_ss = ss0; m_esp = esp0; m_cs = cs; m_eip = eip;
            m_fl = fl & ~32'h0002_0100;
            if (gint) m_fl[9] = 1'b0;
            m_hsel = hsel; m_hoff = hoff; m_n = 0; m_st = 1;
          end
        end
        1: if (rdy) begin
          m_esp = m_esp - 4;
          void'(q.pop_front());
          m_n++;
          if (m_n == 4) begin m_gs = '0; m_fs = '0; m_ds = '0; m_es = '0; end
          if (q.size() == 0) begin m_cs = m_hsel; m_eip = m_hoff; m_st = 2; end
        end
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++; checks++;
      $display("FAIL R8 watchdog expired: actual busy expected idle");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
    if (rst_n) begin
      chk("R1 busy", busy, 32'(m_st != 0));
      chk("R6 req", req, 32'(m_st == 1));
      if (m_st == 1) begin
        chk("R5 addr", addr, m_esp - 4);
        chk("R6 data", wdata, q[0]);
      end
      chk("R8 done", done, 32'(m_st == 2));
      chk("R2 fault", fgp, 32'(m_st == 3));
      chk("R7 gs", gs_d, m_gs); chk("R7 fs", fs_d, m_fs);
      chk("R7 ds", ds_d, m_ds); chk("R7 es", es_d, m_es);
      chk("R4 ss", ss_d, m_ss); chk("R5 esp", esp_d, m_esp);
      chk("R4 flags", fl_d, m_fl);
      chk("R8 cs", cs_d, m_cs); chk("R8 eip", eip_d, m_eip);
    end
  end

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rdy = (stall_mode == 0) ? 1'b1 : lfsr[0];
  end

  task automatic run_evt(string tag, logic g_int, logic [1:0] dpl, logic [1:0] cpl,
                         logic [31:0] flags, logic [15:0] base, logic expect_fault, logic poke);
    @(negedge clk);
    gint = g_int; gdpl = dpl; tcpl = cpl; fl = flags;
    gs = base + 1; fs = base + 2; ds = base + 3; es = base + 4; ss = base + 5; cs = base + 6;
    esp = {base, 16'h0F00}; eip = {base, 16'h1234};
    ss0 = base + 16'h10; esp0 = {16'h0, base} + 32'h0000_8000;
    hsel = base + 16'h20; hoff = {16'hC0DE, base};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(tag, fgp, 32'(expect_fault));
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1'b1; gs = 16'hDEAD; fl = 32'h0000_3000; gdpl = 2'd3; tcpl = 2'd0;
      @(negedge clk);
      start = 1'b0;
    end
    while (m_st != 0) @(negedge clk);
    if (!expect_fault) chk("R8 final esp", esp_d, esp0 - 32'd36);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 busy", busy, 0); chk("R9 req", req, 0);
    chk("R9 done", done, 0); chk("R9 fault", fgp, 0);
    chk("R9 esp", esp_d, 0); chk("R9 flags", fl_d, 0);
    chk("R9 gs", gs_d, 0); chk("R9 eip", eip_d, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_evt("R4 int gate", 1'b1, 2'd3, 2'd0, 32'h0002_3302, 16'h0100, 1'b0, 1'b0);
    stall_mode = 1;
    run_evt("R4 trap gate", 1'b0, 2'd3, 2'd0, 32'h0002_3302, 16'h0200, 1'b0, 1'b0);
    run_evt("R2 iopl2", 1'b1, 2'd3, 2'd0, 32'h0002_2302, 16'h0300, 1'b1, 1'b0);
    run_evt("R2 iopl0", 1'b1, 2'd3, 2'd0, 32'h0002_0302, 16'h0400, 1'b1, 1'b0);
    run_evt("R3 dpl2", 1'b1, 2'd2, 2'd0, 32'h0002_3302, 16'h0500, 1'b1, 1'b0);
    run_evt("R3 cpl1", 1'b0, 2'd3, 2'd1, 32'h0002_3302, 16'h0600, 1'b1, 1'b0);
    run_evt("R1 busy poke", 1'b1, 2'd3, 2'd0, 32'h0002_3202, 16'h0700, 1'b0, 1'b1);
    stall_mode = 0;
    run_evt("R6 back to back", 1'b0, 2'd3, 2'd0, 32'h0002_3100, 16'h0800, 1'b0, 1'b0);
    run_evt("R7 again", 1'b1, 2'd3, 2'd0, 32'h0003_3FD7, 16'h0900, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule